// File: doc/BRIEF.md
# Triggered Logic Capture Recorder

This block records a parallel logic sample stream, four channels wide by default, into an external dynamic memory that uses multiplexed addressing. Each sample address is sent in two halves. The low half goes out as the row and is latched when the row strobe falls. The high half goes out as the column and is latched when the column strobe falls. The block drives the address bus, the active-low row strobe, column strobe and write enable, and the data bus with its output enable. A busy output shows when the block is working.

A capture starts from a record button. When record has stayed released for a fixed number of polls, the block writes samples from address zero up to the top of memory. In free-run mode it writes one sample per fixed slot of cycles. In edge-gated mode every sample waits for a chosen edge on a trigger input. The left and right buttons pick the mode and the edge polarity while the record button is being debounced. If record is pressed while the block waits for an edge, the capture is aborted and every address still unwritten is filled with zeros at free-run pace. After reset the block clears the whole memory the same way. When it is idle, a refresh request makes it step through every row with a row-only strobe.

Top module: `cap_rec_top`

## Requirements
- R1: From reset, busy is high and the block writes zero to every address, from 0 upward, one write per slot. When that is done, busy goes low.
- R2: Each write follows a fixed order. The row (low address half) is driven, then the row strobe falls. Then the column (high address half) is driven, then the column strobe falls, then the column strobe rises, then the row strobe rises. The column strobe is only ever low while the row strobe is low.
- R3: In free-run mode, column-strobe falls come exactly SLOT_CYCLES (14) cycles apart. Each one stores the value that the sample input had at the start of its slot, and the data bus does not change while the column strobe is low.
- R4: A capture starts only after record has been released for DEBOUNCE_POLLS consecutive cycles. A press during that window restarts the count. The first row-strobe fall comes 2 cycles after the last poll of the window.
- R5: While debouncing, a held left button selects the falling trigger edge and a held right button selects the rising edge. If both are held, rising wins. If either button is held on the last poll, the capture is edge-gated. If neither is held, it is free-run.
- R6: In edge-gated mode, no write happens until an edge of the selected polarity appears on the trigger input. Edges of the opposite polarity are ignored. Each write stores the sample value present at the edge.
- R7: A record press while the block waits for an edge ends the gated capture. Every address from the next unwritten one to the top of memory is then written with zero, one write per slot.
- R8: A capture ends after the top address has been written. Busy then goes low, write enable goes high, the data bus is released, and the next capture starts again at address 0.
- R9: A refresh request in idle gives one row-only strobe for each of the 2^(ADDR_W/2) rows, in ascending order. The column strobe and write enable stay high, and busy stays high for exactly two cycles per row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_rec | input | 1 | Record button, 1 = pressed |
| btn_left | input | 1 | Left button, 1 = pressed |
| btn_right | input | 1 | Right button, 1 = pressed |
| trig_in | input | 1 | Trigger input for edge-gated capture |
| smp_in | input | CH_W | Logic channels to record |
| refresh_req | input | 1 | Request a full row refresh (taken in idle) |
| dram_addr | output | ADDR_W/2 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | CH_W | Write data |
| dram_dq_oe | output | 1 | Data bus output enable |
| busy | output | 1 | High whenever the block is not idle |

## Verification
Free-run capture is run twice with different constant sample values, so a stuck or wrongly routed data bit shows up against an all-zero cleared memory. Edge-gated capture is run with a falling-edge selection and with a rising-edge selection. In each run a distinct pattern is written per edge and an opposite-polarity edge is offered first. This separates a wrong polarity choice, a missed sample latch and a write that was not gated. The gated runs are then aborted partway, so the zero fill can be told apart from data left over from earlier runs. A debounce run that is interrupted by a second press checks that the count restarts.

// File: rtl/cap_rec_pkg.sv
package cap_rec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEBOUNCE,
        ST_ARM,
        ST_SLOT,
        ST_REFRESH
    } cap_state_e;

endpackage

// File: rtl/cap_rec_debounce.sv
// Record-button release counter plus mode/polarity capture during the window.
module cap_rec_debounce #(
    parameter int POLLS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rec,
    input  logic left,
    input  logic right,
    output logic done,
    output logic rise_next,
    output logic gated
);
    localparam int CW = $clog2(POLLS + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          rise_d, rise_q;

    always_comb begin
        cnt_d  = cnt_q;
        rise_d = rise_q;
        done   = 1'b0;
        if (!active) begin
            cnt_d = '0;
        end else begin
            if (left)  rise_d = 1'b0;
            if (right) rise_d = 1'b1;
            if (rec) begin
                cnt_d = '0;
            end else if (cnt_q == CW'(POLLS - 1)) begin
                done  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    assign rise_next = rise_d;
    assign gated     = done & (left | right);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rise_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_d;
            rise_q <= rise_d;
        end
    end
endmodule

// File: rtl/cap_rec_edge.sv
// Two-stage trigger history with polarity-selected edge detection.
module cap_rec_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic rise,
    output logic hit
);
    logic [1:0] hist_d, hist_q;

    always_comb begin
        hist_d = {hist_q[0], trig};
    end

    assign hit = rise ? (hist_q[0] & ~hist_q[1]) : (~hist_q[0] & hist_q[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/cap_rec_strobe.sv
// Decodes slot phase or refresh step into address mux and strobes.
module cap_rec_strobe #(
    parameter int HALF_W = 8,
    parameter int PH_W   = 4
) (
    input  logic              slot_on,
    input  logic              refr_on,
    input  logic [PH_W-1:0]   phase,
    input  logic [HALF_W-1:0] row,
    input  logic [HALF_W-1:0] col,
    input  logic [HALF_W-1:0] refr_row,
    input  logic              refr_strobe,
    output logic [HALF_W-1:0] bus,
    output logic              ras_n,
    output logic              cas_n
);
    localparam logic [PH_W-1:0] PH_RAS_LO = PH_W'(2);
    localparam logic [PH_W-1:0] PH_COL    = PH_W'(3);
    localparam logic [PH_W-1:0] PH_CAS_LO = PH_W'(5);
    localparam logic [PH_W-1:0] PH_RAS_HI = PH_W'(7);

    always_comb begin
        bus   = row;
        ras_n = 1'b1;
        cas_n = 1'b1;
        if (slot_on) begin
            ras_n = !(phase >= PH_RAS_LO && phase < PH_RAS_HI);
            cas_n = (phase != PH_CAS_LO);
            if (phase >= PH_COL && phase < PH_RAS_HI) bus = col;
        end else if (refr_on) begin
            bus   = refr_row;
            ras_n = ~refr_strobe;
        end
    end
endmodule

// File: rtl/cap_rec_top.sv
module cap_rec_top
    import cap_rec_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int CH_W           = 4,
    parameter int SLOT_CYCLES    = 14,
    parameter int DEBOUNCE_POLLS = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                btn_rec,
    input  logic                btn_left,
    input  logic                btn_right,
    input  logic                trig_in,
    input  logic [CH_W-1:0]     smp_in,
    input  logic                refresh_req,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic [CH_W-1:0]     dram_dq_out,
    output logic                dram_dq_oe,
    output logic                busy
);
    localparam int ROW_W = ADDR_W / 2;
    localparam int PH_W  = $clog2(SLOT_CYCLES);
    localparam logic [PH_W-1:0]   LAST_PH  = PH_W'(SLOT_CYCLES - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
    localparam logic [ROW_W-1:0]  TOP_ROW  = '1;

    typedef struct packed {
        cap_state_e        st;
        logic [PH_W-1:0]   ph;
        logic [ADDR_W-1:0] addr;
        logic [CH_W-1:0]   data;
        logic              gated;
        logic              rise;
        logic              zero;
        logic [ROW_W-1:0]  rrow;
        logic              rph;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic db_done, db_rise, db_gated, edge_hit;
    logic slot_on, refr_on, cap_on;

    cap_rec_debounce #(.POLLS(DEBOUNCE_POLLS)) u_db (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (ctl_q.st == ST_DEBOUNCE),
        .rec       (btn_rec),
        .left      (btn_left),
        .right     (btn_right),
        .done      (db_done),
        .rise_next (db_rise),
        .gated     (db_gated)
    );

    cap_rec_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig_in),
        .rise  (ctl_q.rise),
        .hit   (edge_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (btn_rec) begin
                    ctl_d.st = ST_DEBOUNCE;
                end else if (refresh_req) begin
                    ctl_d.st   = ST_REFRESH;
                    ctl_d.rrow = '0;
                    ctl_d.rph  = 1'b0;
                end
            end
            ST_DEBOUNCE: begin
                if (db_done) begin
                    ctl_d.addr  = '0;
                    ctl_d.zero  = 1'b0;
                    ctl_d.rise  = db_rise;
                    ctl_d.gated = db_gated;
                    ctl_d.ph    = '0;
                    if (db_gated) begin
                        ctl_d.st = ST_ARM;
                    end else begin
                        ctl_d.st   = ST_SLOT;
                        ctl_d.data = smp_in;
                    end
                end
            end
            ST_ARM: begin
                if (btn_rec) begin
                    ctl_d.zero = 1'b1;
                    ctl_d.data = '0;
                    ctl_d.ph   = '0;
                    ctl_d.st   = ST_SLOT;
                end else if (edge_hit) begin
                    ctl_d.data = smp_in;
                    ctl_d.ph   = '0;
                    ctl_d.st   = ST_SLOT;
                end
            end
            ST_SLOT: begin
                if (ctl_q.ph == LAST_PH) begin
                    ctl_d.ph   = '0;
                    ctl_d.addr = ctl_q.addr + 1'b1;
                    if (ctl_q.addr == TOP_ADDR) begin
                        ctl_d.st    = ST_IDLE;
                        ctl_d.zero  = 1'b0;
                        ctl_d.gated = 1'b0;
                    end else if (ctl_q.gated && !ctl_q.zero) begin
                        ctl_d.st = ST_ARM;
                    end else begin
                        ctl_d.data = ctl_q.zero ? '0 : smp_in;
                    end
                end else begin
                    ctl_d.ph = ctl_q.ph + 1'b1;
                end
            end
            ST_REFRESH: begin
                ctl_d.rph = ~ctl_q.rph;
                if (ctl_q.rph) begin
                    ctl_d.rrow = ctl_q.rrow + 1'b1;
                    if (ctl_q.rrow == TOP_ROW) ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_SLOT;
            ctl_q.ph    <= '0;
            ctl_q.addr  <= '0;
            ctl_q.data  <= '0;
            ctl_q.gated <= 1'b0;
            ctl_q.rise  <= 1'b1;
            ctl_q.zero  <= 1'b1;
            ctl_q.rrow  <= '0;
            ctl_q.rph   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign slot_on = (ctl_q.st == ST_SLOT);
    assign refr_on = (ctl_q.st == ST_REFRESH);
    assign cap_on  = slot_on || (ctl_q.st == ST_ARM);

    cap_rec_strobe #(.HALF_W(ROW_W), .PH_W(PH_W)) u_strb (
        .slot_on     (slot_on),
        .refr_on     (refr_on),
        .phase       (ctl_q.ph),
        .row         (ctl_q.addr[ROW_W-1:0]),
        .col         (ctl_q.addr[ADDR_W-1:ROW_W]),
        .refr_row    (ctl_q.rrow),
        .refr_strobe (ctl_q.rph),
        .bus         (dram_addr),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n)
    );

    assign dram_we_n   = ~cap_on;
    assign dram_dq_oe  = cap_on;
    assign dram_dq_out = ctl_q.data;
    assign busy        = (ctl_q.st != ST_IDLE);
endmodule

// File: rtl/cap_rec_checks.sv
module cap_rec_checks #(
    parameter int BUS_W = 8,
    parameter int DQ_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic [DQ_W-1:0]  dq,
    input logic [BUS_W-1:0] bus
);
    p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    p_ras_before_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!ras_n));

    p_col_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(bus));

    p_data_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> $stable(dq));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (we_n && !dq_oe && ras_n && cas_n));

    p_refresh_no_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we_n) |-> cas_n);
endmodule

bind cap_rec_top cap_rec_checks #(.BUS_W(ROW_W), .DQ_W(CH_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .ras_n (dram_ras_n),
    .cas_n (dram_cas_n),
    .we_n  (dram_we_n),
    .dq_oe (dram_dq_oe),
    .dq    (dram_dq_out),
    .bus   (dram_addr)
);

// File: tb/sim_cap_rec_top.sv
module sim_cap_rec_top;
    localparam int AW   = 8;
    localparam int HW   = AW / 2;
    localparam int DEB  = 100;
    localparam int SLOT = 14;
    localparam int NMEM = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic btn_rec = 0, btn_left = 0, btn_right = 0, trig_in = 0, refresh_req = 0;
    logic [3:0] smp_in = 4'h0;
    logic [HW-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, busy;
    logic [3:0] dram_dq_out;

    always #2 clk = ~clk;

    cap_rec_top #(.ADDR_W(AW), .CH_W(4), .SLOT_CYCLES(SLOT), .DEBOUNCE_POLLS(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_rec(btn_rec), .btn_left(btn_left),
        .btn_right(btn_right), .trig_in(trig_in), .smp_in(smp_in),
        .refresh_req(refresh_req), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .busy(busy)
    );

    int n_chk = 0, n_bad = 0;
    logic [3:0] mem [NMEM];
    int wr_cnt = 0, ord_err = 0, iv_bad = 0, rf_cnt = 0, rf_err = 0, cyc = 0, last_cas = 0;
    bit prev_v = 0, fr_win = 1;
    logic [HW-1:0] row_l = '0, rf_exp = '0;
    logic [AW-1:0] exp_wa = '0, wa;
    logic p_ras = 1, p_cas = 1;

    // behavioural memory and bus monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                row_l = dram_addr;
                if (dram_we_n) begin
                    rf_cnt++;
                    if (dram_addr != rf_exp) rf_err++;
                    rf_exp++;
                end
            end
            if (p_cas && !dram_cas_n && !dram_we_n && dram_dq_oe) begin
                wa = {dram_addr, row_l};
                mem[wa] = dram_dq_out;
                wr_cnt++;
                if (wa != exp_wa) ord_err++;
                exp_wa++;
                if (fr_win && prev_v && (cyc - last_cas) != SLOT) iv_bad++;
                prev_v = 1;
                last_cas = cyc;
            end
        end
        p_ras = dram_ras_n;
        p_cas = dram_cas_n;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle(input string tag);
        int k;
        k = 0;
        while (busy && k < 20000) begin tick(1); k++; end
        check({tag, " busy drops"}, int'(busy), 0);
    endtask

    task automatic mem_range(input string tag, input int lo, input int hi, input logic [3:0] v);
        int bad;
        bad = 0;
        for (int i = lo; i < hi; i++) if (mem[i] !== v) bad++;
        check(tag, bad, 0);
    endtask

    task automatic idle_outputs(input string tag);
        check({tag, " we_n high"}, int'(dram_we_n), 1);
        check({tag, " bus released"}, int'(dram_dq_oe), 0);
    endtask

    // R1: power-up clear
    task automatic t_powerup;
        tick(1);
        check("R1 busy after reset", int'(busy), 1);
        check("R1 write enabled", int'(dram_we_n), 0);
        wait_idle("R1");
        check("R1 write count", wr_cnt, NMEM);
        mem_range("R1 all cleared", 0, NMEM, 4'h0);
        check("R2 address order", ord_err, 0);
        check("R3 clear slot spacing", iv_bad, 0);
        idle_outputs("R8 after clear");
    endtask

    // R3 R4 R5 R8: free-run capture with interrupted debounce
    task automatic t_free_run(input logic [3:0] v, input bit interrupt);
        int k, w0;
        smp_in = v;
        w0 = wr_cnt;
        prev_v = 0;
        fr_win = 1;
        btn_rec = 1; tick(3); btn_rec = 0;
        if (interrupt) begin
            tick(40);
            check("R4 busy in window", int'(busy), 1);
            check("R4 no write in window", wr_cnt - w0, 0);
            btn_rec = 1; tick(2); btn_rec = 0;
        end
        k = 0;
        while (dram_ras_n && k < 500) begin tick(1); k++; end
        check("R4 first row strobe delay", k, DEB + 2);
        wait_idle("R8");
        check("R5 free-run writes all", wr_cnt - w0, NMEM);
        mem_range("R3 stored value", 0, NMEM, v);
        check("R3 slot spacing", iv_bad, 0);
        check("R2 address order", ord_err, 0);
        idle_outputs("R8 end");
    endtask

    // R5 R6 R7: edge-gated capture, then abort
    task automatic t_gated(input bit use_right);
        int w0, k;
        w0 = wr_cnt;
        fr_win = 0;
        trig_in = use_right;    // park on the level opposite to the wanted edge
        btn_rec = 1;
        if (use_right) btn_right = 1; else btn_left = 1;
        tick(3); btn_rec = 0;
        tick(DEB + 5);
        btn_left = 0; btn_right = 0;
        tick(30);
        check("R6 no write before edge", wr_cnt - w0, 0);
        check("R5 gated mode armed busy", int'(busy), 1);
        for (int i = 0; i < 6; i++) begin
            smp_in = 4'(i * 5 + (use_right ? 3 : 1));
            tick(3);
            trig_in = ~trig_in;     // wrong polarity
            tick(12);
            check("R6 opposite edge ignored", wr_cnt - w0, i);
            trig_in = ~trig_in;     // wanted polarity
            tick(22);
            check("R6 one write per edge", wr_cnt - w0, i + 1);
        end
        for (int i = 0; i < 6; i++)
            check("R6 sample at edge", int'(mem[i]), (i * 5 + (use_right ? 3 : 1)) & 15);
        prev_v = 0;
        fr_win = 1;
        btn_rec = 1; tick(1); btn_rec = 0;
        k = 0;
        wait_idle("R7");
        mem_range("R7 zero fill", 6, NMEM, 4'h0);
        check("R7 fill count", wr_cnt - w0, NMEM);
        check("R7 fill slot spacing", iv_bad, 0);
        check("R2 address order", ord_err, 0);
        idle_outputs("R8 after abort");
    endtask

    // R9: refresh
    task automatic t_refresh;
        int r0, nb;
        r0 = rf_cnt;
        refresh_req = 1; tick(1); refresh_req = 0;
        nb = 0;
        while (busy && nb < 1000) begin nb++; tick(1); end
        check("R9 row strobe count", rf_cnt - r0, 1 << HW);
        check("R9 row order", rf_err, 0);
        check("R9 busy cycles", nb, 2 * (1 << HW));
        idle_outputs("R9 end");
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all-R actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NMEM; i++) mem[i] = 4'hF;
        tick(3);
        rst_n = 1'b1;
        t_powerup();
        t_refresh();
        t_free_run(4'hA, 1'b1);
        t_free_run(4'h5, 1'b0);
        t_gated(1'b0);
        t_gated(1'b1);
        t_refresh();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule